// File: doc/BRIEF.md
# Unary Marker Population Counter

This block counts the ones in an unordered unary word, such as the raw outputs of a bank of comparators with scrambled thresholds. A single marker bit enters a cascade of two-way mux rows at line 0. Each input bit drives the select of one row. A set bit pushes the marker one line higher, and a clear bit leaves it on its line. After the last row the marker sits on the line whose index is the number of ones. That line is the one-hot result. An OR matrix then folds it into a binary count.

Both results and a legality flag are registered. A result is captured on every clock edge where the sample enable is high. On any edge where the enable is low, the output register is cleared instead. This stands in for the per-cycle precharge of a passive mux array: the outputs show no stale marker. With the default width of seven inputs, the block gives an eight-line one-hot vector and a three-bit count.

Top module: `unary_marker_counter`

## Requirements
- R1: With all input bits clear, the marker stays on line 0. A loaded result then shows `onehot_o` = 8'b0000_0001 and `count_o` = 0.
- R2: Each set input bit moves the marker up by exactly one line, and each clear bit leaves it where it is. The result depends only on how many bits are set, not on which ones.
- R3: A result loaded with `smp_en` high has exactly one bit set in `onehot_o`. In every state, `onehot_o` never has more than one bit set.
- R4: `count_o` is the binary index of the set line of `onehot_o`. Bit b of the count is the OR of every line whose index has bit b set.
- R5: On a clock edge with `smp_en` low, `onehot_o` becomes all zeros, `count_o` becomes 0 and `err_o` becomes 0, whatever `unary_i` holds.
- R6: `err_o` is set only when a loaded one-hot result does not have exactly one set line. For every input pattern it therefore reads 0.
- R7: A result appears on the outputs one clock edge after `unary_i` is sampled with `smp_en` high. Until that edge, the outputs keep their previous values.
- R8: While `rst_n` is low, all outputs read 0; this takes effect at once, without a clock edge. Release of `rst_n` is synchronised over two clock edges.
- R9: With the default N_IN = 7, `onehot_o` is 8 bits wide and `count_o` is 3 bits wide. All seven inputs set gives line 7 and a count of 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised |
| smp_en | input | 1 | Sample enable: load a result when high, clear the outputs when low |
| unary_i | input | N_IN | Unordered unary input word, one bit per mux row |
| onehot_o | output | N_IN+1 | Registered marker position, one line per possible count |
| count_o | output | $clog2(N_IN+1) | Registered binary count of ones |
| err_o | output | 1 | Registered flag for a one-hot result without exactly one set line |

## Verification
The input patterns include all-clear, all-set, single ones at the lowest and highest rows, and alternating bit patterns. They also include several different words with the same number of ones, placed at different rows. The equal-weight groups show that the marker tracks the count and not the bit positions. The single-one and alternating cases separate a row that moves the marker by the wrong amount, or in the wrong direction, from one that is simply wired to the wrong input. The all-clear case separates a missing seed from a correct count of zero. Directed steps then check the one-edge latency, the cleared output on a disabled edge, and the immediate clear when reset is asserted in the middle of a run.

// File: rtl/umc_pkg.sv
package umc_pkg;
  localparam int unsigned UMC_DEF_N = 7;

  function automatic int unsigned umc_cnt_w(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/umc_mux_row.sv
module umc_mux_row #(
  parameter int unsigned W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] in_vec,
  output logic [W-1:0] out_vec
);
  // Each line is a two-way mux.
  // sel=1 takes the marker from the line below; sel=0 keeps the line's own value.
  for (genvar j = 0; j < W; j++) begin : g_line
    if (j == 0) begin : g_bottom
      assign out_vec[j] = sel ? 1'b0 : in_vec[j];
    end else begin : g_upper
      assign out_vec[j] = sel ? in_vec[j-1] : in_vec[j];
    end
  end
endmodule

// File: rtl/umc_cascade.sv
module umc_cascade #(
  parameter int unsigned N_IN = 7,
  localparam int unsigned OH_W = N_IN + 1
) (
  input  logic [N_IN-1:0] sel_i,
  output logic [OH_W-1:0] marker_o
);
  logic [OH_W-1:0] stage [0:N_IN];

  // The marker is seeded on line 0; every other line starts empty.
  assign stage[0] = OH_W'(1);

  for (genvar r = 0; r < N_IN; r++) begin : g_row
    umc_mux_row #(.W(OH_W)) row_i (
      .sel     (sel_i[r]),
      .in_vec  (stage[r]),
      .out_vec (stage[r+1])
    );
  end

  assign marker_o = stage[N_IN];
endmodule

// File: rtl/umc_encoder.sv
module umc_encoder #(
  parameter int unsigned OH_W = 8,
  localparam int unsigned BW = (OH_W < 2) ? 1 : $clog2(OH_W)
) (
  input  logic [OH_W-1:0] onehot_i,
  output logic [BW-1:0]   bin_o
);
  // OR matrix: bit b collects every line whose index has bit b set.
  for (genvar b = 0; b < BW; b++) begin : g_bit
    logic [OH_W-1:0] mask;
    for (genvar j = 0; j < OH_W; j++) begin : g_tap
      assign mask[j] = ((j >> b) & 1) != 0;
    end
    assign bin_o[b] = |(onehot_i & mask);
  end
endmodule

// File: rtl/umc_legal_check.sv
module umc_legal_check #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] vec_i,
  output logic         single_o
);
  logic          any_set;
  logic [W-1:0]  low_cleared;

  assign any_set     = |vec_i;
  assign low_cleared = vec_i & (vec_i - W'(1));
  assign single_o    = any_set && (low_cleared == '0);
endmodule

// File: rtl/unary_marker_counter.sv
module unary_marker_counter
  import umc_pkg::*;
#(
  parameter int unsigned N_IN = UMC_DEF_N,
  localparam int unsigned OH_W = N_IN + 1,
  localparam int unsigned CW   = umc_cnt_w(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_en,
  input  logic [N_IN-1:0] unary_i,
  output logic [OH_W-1:0] onehot_o,
  output logic [CW-1:0]   count_o,
  output logic            err_o
);
  // Reset: asserts asynchronously, releases after two clock edges.
  logic rst_meta_n;
  logic rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_n_sync <= rst_meta_n;
    end
  end

  // Combinational datapath.
  logic [OH_W-1:0] marker_c;
  logic [CW-1:0]   bin_c;
  logic            single_c;

  umc_cascade #(.N_IN(N_IN)) cascade_i (
    .sel_i    (unary_i),
    .marker_o (marker_c)
  );

  umc_encoder #(.OH_W(OH_W)) encoder_i (
    .onehot_i (marker_c),
    .bin_o    (bin_c)
  );

  umc_legal_check #(.W(OH_W)) legal_i (
    .vec_i    (marker_c),
    .single_o (single_c)
  );

  // Next state: load on enable, otherwise clear, like the per-cycle precharge.
  logic [OH_W-1:0] onehot_d;
  logic [CW-1:0]   count_d;
  logic            err_d;

  always_comb begin
    if (smp_en) begin
      onehot_d = marker_c;
      count_d  = bin_c;
      err_d    = !single_c;
    end else begin
      onehot_d = '0;
      count_d  = '0;
      err_d    = 1'b0;
    end
  end

  // Output registers.
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      onehot_o <= '0;
      count_o  <= '0;
      err_o    <= 1'b0;
    end else begin
      onehot_o <= onehot_d;
      count_o  <= count_d;
      err_o    <= err_d;
    end
  end
endmodule

// File: rtl/unary_marker_counter_chk.sv
module unary_marker_counter_chk #(
  parameter int unsigned N_IN = 7,
  localparam int unsigned OH_W = N_IN + 1,
  localparam int unsigned CW   = (N_IN < 1) ? 1 : $clog2(N_IN + 1)
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            smp_en,
  input logic [N_IN-1:0] unary_i,
  input logic [OH_W-1:0] onehot_o,
  input logic [CW-1:0]   count_o,
  input logic            err_o
);
  // Goes high one edge after reset release, so that $past only reaches live cycles.
  logic seen;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) seen <= 1'b0;
    else             seen <= 1'b1;
  end

  AST_ONEHOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seen && $past(smp_en) |-> $countones(onehot_o) == 1); // R3

  AST_ONEHOT_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(onehot_o)); // R3

  AST_COUNT_IS_POP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seen && $past(smp_en) |-> count_o == CW'($countones($past(unary_i)))); // R2

  AST_ENC_MATCHES_LINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    onehot_o != '0 |-> onehot_o[count_o]); // R4

  AST_CLEARED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seen && !$past(smp_en) |-> (onehot_o == '0) && (count_o == '0) && !err_o); // R5

  AST_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !err_o); // R6

  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seen && $past(smp_en) && ($past(unary_i) == '0) |-> onehot_o == OH_W'(1)); // R1
endmodule

bind unary_marker_counter unary_marker_counter_chk #(.N_IN(N_IN)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_n_sync),
  .smp_en     (smp_en),
  .unary_i    (unary_i),
  .onehot_o   (onehot_o),
  .count_o    (count_o),
  .err_o      (err_o)
);

// File: tb/unary_marker_counter_tb_top.sv
module unary_marker_counter_tb_top;
  localparam int NI = 7;
  localparam int NV = 12;

  logic         clk;
  logic         rst_n;
  logic         smp_en;
  logic [NI-1:0] unary_i;
  logic [NI:0]   onehot_o;
  logic [2:0]    count_o;
  logic          err_o;

  int n_checks;
  int n_errors;
  int cycles;

  // Each entry: {input word, expected number of ones}.
  localparam logic [9:0] VEC [NV] = '{
    {7'b0000000, 3'd0},
    {7'b0000001, 3'd1},
    {7'b1000000, 3'd1},
    {7'b0010000, 3'd1},
    {7'b0101010, 3'd3},
    {7'b1001001, 3'd3},
    {7'b0011100, 3'd3},
    {7'b1010101, 3'd4},
    {7'b1100011, 3'd4},
    {7'b0111111, 3'd6},
    {7'b1110111, 3'd6},
    {7'b1111111, 3'd7}
  };

  unary_marker_counter #(.N_IN(NI)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .unary_i  (unary_i),
    .onehot_o (onehot_o),
    .count_o  (count_o),
    .err_o    (err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    cycles   = 0;
    rst_n    = 1'b0;
    smp_en   = 1'b0;
    unary_i  = '0;

    repeat (3) @(negedge clk);
    check("R8", "reset onehot", 32'(onehot_o), 0);
    check("R8", "reset count",  32'(count_o),  0);
    check("R8", "reset err",    32'(err_o),    0);

    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "after release onehot", 32'(onehot_o), 0);

    // Table walk, back to back with the enable held high (R1 R2 R3 R4 R6 R9).
    for (int i = 0; i < NV; i++) begin
      unary_i = VEC[i][9:3];
      smp_en  = 1'b1;
      @(negedge clk);
      check("R2", $sformatf("vec %0d onehot", i), 32'(onehot_o), 32'(9'd1 << VEC[i][2:0]));
      check("R4", $sformatf("vec %0d count", i),  32'(count_o),  32'(VEC[i][2:0]));
      check("R6", $sformatf("vec %0d err", i),    32'(err_o),    0);
      if (VEC[i][2:0] == 3'd0)
        check("R1", "zero input seeds line 0", 32'(onehot_o), 1);
      if (VEC[i][2:0] == 3'd7)
        check("R9", "all ones reaches top line", 32'(onehot_o[7]), 1);
      check("R3", $sformatf("vec %0d single line", i), 32'($countones(onehot_o)), 1);
    end

    // R7: a new input shows nothing before the next edge, then appears after it.
    unary_i = 7'b0000011;
    #1;
    check("R7", "before edge count", 32'(count_o), 7);
    @(negedge clk);
    check("R7", "after edge count",  32'(count_o), 2);
    check("R7", "after edge onehot", 32'(onehot_o), 32'(8'b0000_0100));

    // R5: a disabled edge clears the outputs whatever the input holds.
    smp_en  = 1'b0;
    unary_i = 7'b1111111;
    @(negedge clk);
    check("R5", "idle onehot", 32'(onehot_o), 0);
    check("R5", "idle count",  32'(count_o),  0);
    check("R5", "idle err",    32'(err_o),    0);
    @(negedge clk);
    check("R5", "idle second edge onehot", 32'(onehot_o), 0);

    // R8: reset asserted in the middle of a run clears at once, with no edge.
    smp_en  = 1'b1;
    unary_i = 7'b0101010;
    @(negedge clk);
    check("R4", "pre-reset count", 32'(count_o), 3);
    rst_n = 1'b0;
    #1;
    check("R8", "async clear onehot", 32'(onehot_o), 0);
    check("R8", "async clear count",  32'(count_o),  0);
    @(negedge clk);
    smp_en = 1'b0;
    rst_n  = 1'b1;
    repeat (3) @(negedge clk);
    smp_en  = 1'b1;
    unary_i = 7'b1000001;
    @(negedge clk);
    check("R2", "after reset count", 32'(count_o), 2);

    finish_run();
  end
endmodule